// File: doc/BRIEF.md
# Per-Requester Masked Victim Way Selector

This block decides which way of a 16-way set-associative cache receives a new line when an allocation is requested. Two limits decide which ways a given allocation may use. The first is a global ceiling value: only ways whose index is at or below it act as cache, and the ways above it are left as directly addressed local memory. The second is a mask that each requester owns. A cleared mask bit stops that requester from ever replacing the matching way. Way 0 always counts as cache, whatever the ceiling holds. Scratchpad storage is taken from the bottom ways upward, and it is kept safe by clearing those low bits in the mask of every requester.

On an allocate strobe the block takes the requester number and the valid bits of the addressed set. One cycle later it reports a way index, the same choice as a one-hot vector, and a flag that is set when nothing is eligible. If an eligible way is empty, the block fills it. If every eligible way is full, a rotating pointer spreads the replacements across the eligible ways. A small write/read port holds the ceiling and the fifteen masks.

Top module: `way_victim_sel`

## Requirements
- R1: A chosen way never has an index above the ceiling register, except way 0. The ceiling register sits at config address 0.
- R2: Way 0 stays eligible when the ceiling is 0, so long as the requester's mask bit 0 is set.
- R3: Requester r (0 to 14) owns the 16-bit mask at config address r+1. Bit w of that mask equal to 0 excludes way w for that requester. Requester number 15 has no mask, so it never gets a victim.
- R4: If any eligible way has its valid bit at 0, the lowest-numbered such way is chosen.
- R5: If every eligible way is valid, the chosen way is the first eligible index at or above the rotating pointer, with the search wrapping from 15 back to 0.
- R6: After each allocation that yields a victim, the pointer becomes (chosen index + 1) mod 16.
- R7: With no eligible way, the flag reads 1, the one-hot vector reads 0, the index reads 0, and the pointer keeps its value.
- R8: Reset leaves the ceiling at 7, every mask at 0xFFFF, the pointer at 0 and all result outputs at 0.
- R9: A write of a value above 15 to config address 0 stores 15, and the stored value reads back at config address 0.
- R10: A ceiling write governs the allocations after it. An allocation in the same cycle as the write still uses the old value.
- R11: The result-valid output is high exactly in the cycle after a strobe, and every result output is 0 in all other cycles. When a victim exists, the one-hot vector equals 1 shifted left by the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config address: 0 is the ceiling, r+1 is the mask of requester r |
| cfg_wdata | input | 16 | Config write data |
| cfg_rdata | output | 16 | Config read data for cfg_addr (combinational) |
| alloc_req | input | 1 | Allocate strobe |
| alloc_id | input | 4 | Requester number |
| way_valid | input | 16 | Valid bits of the addressed set |
| vic_vld | output | 1 | Result valid, one cycle after the strobe |
| vic_idx | output | 4 | Chosen way index |
| vic_onehot | output | 16 | Chosen way as a one-hot vector |
| vic_none | output | 1 | No eligible way |

## Verification
Several rules are checked on every cycle: the one-cycle result pulse, the agreement between the index and the one-hot vector, the ceiling limit on the chosen way, the zero vector and unchanged pointer when there is no victim, and the pointer stepping past each victim. Other behaviour only shows up in the bench's scenarios. These include mask protection of scratchpad ways, the preference for empty ways, wrap-around of the rotation, saturation of the ceiling, and a ceiling write that collides with an allocation in the same cycle.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int unsigned DEF_WAYS   = 16;
  localparam int unsigned DEF_REQS   = 15;
  localparam int unsigned DEF_CEIL   = 7;

  // clamp a written ceiling to the highest way index
  function automatic int unsigned clamp_ceiling(input int unsigned wr, input int unsigned top);
    return (wr > top) ? top : wr;
  endfunction
endpackage

// File: rtl/vsel_cfg_regs.sv
module vsel_cfg_regs
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = DEF_WAYS,
  parameter int unsigned NUM_REQ  = DEF_REQS,
  parameter int unsigned ADDR_W   = $clog2(NUM_REQ + 1),
  parameter int unsigned IDX_W    = $clog2(NUM_WAYS),
  parameter int unsigned ID_W     = $clog2(NUM_REQ + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [NUM_WAYS-1:0] cfg_wdata,
  output logic [NUM_WAYS-1:0] cfg_rdata,
  input  logic [ID_W-1:0]     req_id,
  output logic [IDX_W-1:0]    ceil_q,
  output logic [NUM_WAYS-1:0] req_mask
);
  localparam int unsigned TOP_WAY = NUM_WAYS - 1;

  logic [IDX_W-1:0]    ceil_d;
  logic                ceil_en;
  logic [NUM_WAYS-1:0] mask_q [NUM_REQ];

  // ceiling register: next-state then storage
  always_comb begin
    ceil_en = cfg_we && (cfg_addr == '0);
    ceil_d  = IDX_W'(clamp_ceiling(int'(cfg_wdata), TOP_WAY));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ceil_q <= IDX_W'(DEF_CEIL);
    else if (ceil_en) ceil_q <= ceil_d;
  end

  // one mask register per requester
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_mask
    logic m_en;
    always_comb m_en = cfg_we && (int'(cfg_addr) == r + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q[r] <= '1;
      else if (m_en) mask_q[r] <= cfg_wdata;
    end
  end

  // requester mask lookup; unknown ids get an empty mask
  always_comb begin
    req_mask = '0;
    for (int r = 0; r < NUM_REQ; r++)
      if (int'(req_id) == r) req_mask = mask_q[r];
  end

  // read-back mux
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == '0) cfg_rdata = NUM_WAYS'(ceil_q);
    for (int r = 0; r < NUM_REQ; r++)
      if (int'(cfg_addr) == r + 1) cfg_rdata = mask_q[r];
  end
endmodule

// File: rtl/vsel_elig.sv
module vsel_elig
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = DEF_WAYS,
  parameter int unsigned IDX_W    = $clog2(NUM_WAYS)
) (
  input  logic [IDX_W-1:0]    ceil_val,
  input  logic [NUM_WAYS-1:0] req_mask,
  output logic [NUM_WAYS-1:0] elig
);
  logic [NUM_WAYS-1:0] cache_ways;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    if (w == 0) begin : g_base
      // the lowest way is always cache
      assign cache_ways[w] = 1'b1;
    end else begin : g_upper
      assign cache_ways[w] = (IDX_W'(w) <= ceil_val);
    end
  end

  assign elig = cache_ways & req_mask;
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = DEF_WAYS,
  parameter int unsigned IDX_W    = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] elig,
  input  logic [NUM_WAYS-1:0] valid,
  input  logic [IDX_W-1:0]    ptr,
  output logic                found,
  output logic [IDX_W-1:0]    pick
);
  logic [NUM_WAYS-1:0] empty_ways;
  logic                hit_empty;
  logic [IDX_W-1:0]    idx_empty;
  logic                hit_rr;
  logic [IDX_W-1:0]    idx_rr;

  // lowest eligible empty way
  always_comb begin
    empty_ways = elig & ~valid;
    hit_empty  = 1'b0;
    idx_empty  = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (empty_ways[i]) begin
        hit_empty = 1'b1;
        idx_empty = IDX_W'(i);
      end
    end
  end

  // first eligible way at or after the pointer, wrapping
  always_comb begin
    hit_rr = 1'b0;
    idx_rr = '0;
    for (int k = NUM_WAYS - 1; k >= 0; k--) begin
      int unsigned pos;
      pos = (int'(ptr) + k) % NUM_WAYS;
      if (elig[pos]) begin
        hit_rr = 1'b1;
        idx_rr = IDX_W'(pos);
      end
    end
  end

  always_comb begin
    found = hit_empty | hit_rr;
    pick  = hit_empty ? idx_empty : idx_rr;
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = DEF_WAYS,
  parameter int unsigned NUM_REQ  = DEF_REQS,
  localparam int unsigned IDX_W   = $clog2(NUM_WAYS),
  localparam int unsigned ADDR_W  = $clog2(NUM_REQ + 1),
  localparam int unsigned ID_W    = $clog2(NUM_REQ + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [NUM_WAYS-1:0] cfg_wdata,
  output logic [NUM_WAYS-1:0] cfg_rdata,
  input  logic                alloc_req,
  input  logic [ID_W-1:0]     alloc_id,
  input  logic [NUM_WAYS-1:0] way_valid,
  output logic                vic_vld,
  output logic [IDX_W-1:0]    vic_idx,
  output logic [NUM_WAYS-1:0] vic_onehot,
  output logic                vic_none
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [IDX_W-1:0]    ceil_q;
  logic [NUM_WAYS-1:0] req_mask;
  logic [NUM_WAYS-1:0] elig;
  logic                found;
  logic [IDX_W-1:0]    pick;
  logic [IDX_W-1:0]    rr_ptr, rr_ptr_d;
  logic                ptr_en;
  logic                vld_d, none_d;
  logic [IDX_W-1:0]    idx_d;
  logic [NUM_WAYS-1:0] onehot_d;

  vsel_cfg_regs #(.NUM_WAYS(NUM_WAYS), .NUM_REQ(NUM_REQ)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_id    (alloc_id),
    .ceil_q    (ceil_q),
    .req_mask  (req_mask)
  );

  vsel_elig #(.NUM_WAYS(NUM_WAYS)) u_elig (
    .ceil_val (ceil_q),
    .req_mask (req_mask),
    .elig     (elig)
  );

  vsel_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .elig  (elig),
    .valid (way_valid),
    .ptr   (rr_ptr),
    .found (found),
    .pick  (pick)
  );

  // next-state
  always_comb begin
    ptr_en   = alloc_req && found;
    rr_ptr_d = (int'(pick) == NUM_WAYS - 1) ? '0 : pick + 1'b1;
    vld_d    = alloc_req;
    none_d   = alloc_req && !found;
    idx_d    = (alloc_req && found) ? pick : '0;
    onehot_d = '0;
    if (alloc_req && found) onehot_d[pick] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rr_ptr <= '0;
    else if (ptr_en)  rr_ptr <= rr_ptr_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vic_vld    <= 1'b0;
      vic_none   <= 1'b0;
      vic_idx    <= '0;
      vic_onehot <= '0;
    end else begin
      vic_vld    <= vld_d;
      vic_none   <= none_d;
      vic_idx    <= idx_d;
      vic_onehot <= onehot_d;
    end
  end
endmodule

// File: rtl/way_victim_sel_chk.sv
module way_victim_sel_chk #(
  parameter int unsigned NUM_WAYS = 16,
  parameter int unsigned IDX_W    = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_req,
  input logic                vic_vld,
  input logic [IDX_W-1:0]    vic_idx,
  input logic [NUM_WAYS-1:0] vic_onehot,
  input logic                vic_none,
  input logic [IDX_W-1:0]    ceil_q,
  input logic [IDX_W-1:0]    rr_ptr
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R11: result pulse follows the strobe by one cycle
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (vic_vld == $past(alloc_req)));

  // R11: one-hot vector agrees with the index
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_vld && !vic_none) |-> (vic_onehot == (NUM_WAYS'(1) << vic_idx)));

  // R11: outputs quiet outside the pulse
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_vld |-> (vic_onehot == '0 && !vic_none));

  // R1: chosen way respects the ceiling in force at the strobe
  p_ceiling_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vic_vld && !vic_none) |-> (vic_idx == '0 || vic_idx <= $past(ceil_q)));

  // R7: empty eligible set gives a zero vector and a held pointer
  p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vic_vld && vic_none) |-> (vic_onehot == '0 && rr_ptr == $past(rr_ptr)));

  // R6: pointer steps past the chosen way
  p_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_vld && !vic_none) |-> (rr_ptr == IDX_W'(vic_idx + 1'b1)));
endmodule

bind way_victim_sel way_victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .alloc_req  (alloc_req),
  .vic_vld    (vic_vld),
  .vic_idx    (vic_idx),
  .vic_onehot (vic_onehot),
  .vic_none   (vic_none),
  .ceil_q     (ceil_q),
  .rr_ptr     (rr_ptr)
);

// File: tb/way_victim_sel_tb.sv
`timescale 1ns/1ps
module way_victim_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        alloc_req;
  logic [3:0]  alloc_id;
  logic [15:0] way_valid;
  logic        vic_vld;
  logic [3:0]  vic_idx;
  logic [15:0] vic_onehot;
  logic        vic_none;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  way_victim_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .alloc_req(alloc_req),
    .alloc_id(alloc_id), .way_valid(way_valid), .vic_vld(vic_vld),
    .vic_idx(vic_idx), .vic_onehot(vic_onehot), .vic_none(vic_none)
  );

  // {id[3:0], valid[15:0], none, idx[3:0]}; masks: r0 FFFF, r1 FFF0, r2 0000, r3 0100, r4 0001
  localparam logic [24:0] VEC [10] = '{
    {4'd0,  16'h0000, 1'b0, 4'd0},
    {4'd0,  16'h0007, 1'b0, 4'd3},
    {4'd1,  16'h0000, 1'b0, 4'd4},
    {4'd1,  16'h0030, 1'b0, 4'd6},
    {4'd2,  16'h0000, 1'b1, 4'd0},
    {4'd3,  16'h0000, 1'b1, 4'd0},
    {4'd4,  16'h0000, 1'b0, 4'd0},
    {4'd0,  16'h00FE, 1'b0, 4'd0},
    {4'd1,  16'hFF50, 1'b0, 4'd5},
    {4'd15, 16'h0000, 1'b1, 4'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string tag, input logic [3:0] a, input int exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic alloc(input string tag, input logic [3:0] id, input logic [15:0] vv,
                       input bit exp_none, input int exp_idx,
                       input bit wr, input logic [15:0] wd);
    @(negedge clk);
    alloc_req = 1'b1; alloc_id = id; way_valid = vv;
    if (wr) begin cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = wd; end
    @(negedge clk);
    alloc_req = 1'b0; cfg_we = 1'b0;
    check({tag, " R11 vld"}, int'(vic_vld), 1);
    check({tag, " none"}, int'(vic_none), int'(exp_none));
    check({tag, " idx"}, int'(vic_idx), exp_none ? 0 : exp_idx);
    check({tag, " R11 onehot"}, int'(vic_onehot), exp_none ? 0 : (1 << exp_idx));
    @(negedge clk);
    check({tag, " R11 pulse end"}, int'(vic_vld), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    alloc_req = 1'b0; alloc_id = '0; way_valid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    check("R8 vld", int'(vic_vld), 0);
    check("R8 onehot", int'(vic_onehot), 0);
    check("R8 none", int'(vic_none), 0);
    cfg_read("R8 ceiling", 4'd0, 7);
    cfg_read("R8 mask r0", 4'd1, 16'hFFFF);
    cfg_read("R8 mask r14", 4'd15, 16'hFFFF);
    alloc("R8 R5 pointer at 0", 4'd0, 16'hFFFF, 1'b0, 0, 1'b0, '0);

    // masks: scratchpad ways 0-3 hidden from r1 (R3)
    cfg_write(4'd2, 16'hFFF0);
    cfg_write(4'd3, 16'h0000);
    cfg_write(4'd4, 16'h0100);
    cfg_write(4'd5, 16'h0001);
    cfg_read("R3 mask r1", 4'd2, 16'hFFF0);

    // R1 R3 R4 R7 table
    for (int i = 0; i < 10; i++) begin
      alloc($sformatf("R1 R3 R4 R7 vec%0d", i), VEC[i][24:21], VEC[i][20:5],
            VEC[i][4], int'(VEC[i][3:0]), 1'b0, '0);
    end
    // pointer is 6 after vec8 (way 5)

    // R5 R6 rotation within ceiling 7
    alloc("R5 R6 rr a", 4'd0, 16'hFFFF, 1'b0, 6, 1'b0, '0);
    alloc("R5 R6 rr b", 4'd0, 16'hFFFF, 1'b0, 7, 1'b0, '0);
    alloc("R1 R5 rr wrap", 4'd0, 16'hFFFF, 1'b0, 0, 1'b0, '0);
    alloc("R5 R6 rr c", 4'd0, 16'hFFFF, 1'b0, 1, 1'b0, '0);

    // R2 ceiling 0 keeps way 0
    cfg_write(4'd0, 16'd0);
    cfg_read("R2 ceiling 0", 4'd0, 0);
    alloc("R2 way0", 4'd0, 16'hFFFF, 1'b0, 0, 1'b0, '0);
    alloc("R2 R3 masked", 4'd1, 16'hFFFF, 1'b1, 0, 1'b0, '0);

    // R9 saturation; R7 pointer held (still 1)
    cfg_write(4'd0, 16'h0020);
    cfg_read("R9 saturate", 4'd0, 15);
    alloc("R7 ptr held", 4'd0, 16'hFFFF, 1'b0, 1, 1'b0, '0);
    alloc("R9 way8", 4'd3, 16'h0000, 1'b0, 8, 1'b0, '0);

    // R10 write colliding with allocation
    alloc("R10 same cycle", 4'd3, 16'h0000, 1'b0, 8, 1'b1, 16'd0);
    alloc("R10 next", 4'd3, 16'h0000, 1'b1, 0, 1'b0, '0);

    // R5 full wrap at ceiling 15, pointer at 9
    cfg_write(4'd0, 16'd15);
    for (int k = 9; k < 16; k++)
      alloc($sformatf("R5 R6 sweep %0d", k), 4'd0, 16'hFFFF, 1'b0, k, 1'b0, '0);
    alloc("R5 R6 wrap 15->0", 4'd0, 16'hFFFF, 1'b0, 0, 1'b0, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule